// File: doc/BRIEF.md
# Port-Mapped SPI Flash Command Engine

This block is an SPI master that a host drives through eight byte-wide port registers. The host writes an opcode, up to three address bytes and one optional payload byte. It then writes a control byte. The control byte selects how many bytes go out, how many response bytes come back, and whether the fast or the slow serial clock is used. The engine sends the bytes in SPI mode 0 under one chip-select assertion, shifts in up to three response bytes, and reports a busy flag in the status register while it works.

A second mode serves page programming. The host enters this mode with a control write. It then issues memory writes, each carrying a 24-bit address and a data byte. The first memory write opens chip select and sends the stored opcode, the three address bytes and the data byte. Each later memory write sends only its data byte, and chip select stays low between them. The number of data bytes in one session is capped. A control write of zero closes the session.

The two serial clock rates are set by parameters. Each parameter counts system clocks per half period of the serial clock.

Top module: `spi_port_engine`

## Requirements
- R1: After a synchronous reset the status register (offset 0) reads 0x00, chip select is high and the serial clock is low.
- R2: A control write whose upper nibble is 0x4 (slow) or 0x5 (fast) starts a transfer, and status bit 7 (busy) reads 1 in the cycle after the write. A control write with any other upper nibble except 0x2, 0x3 (and 0x0 in page mode) is ignored: chip select stays high and status stays 0x00.
- R3: The control bits [1:0] select the bytes sent after the opcode (offset 1). Code 0 sends the opcode alone. Code 1 adds the payload byte from offset 7. Code 2 adds the address bytes from offsets 4, 3 and 2, in that order. Code 3 adds the same three address bytes followed by the payload byte.
- R4: The control bits [3:2] give a read count N from 0 to 3. After the written bytes, N bytes of 0x00 are sent. The bytes received during them read back at offsets 5, 6 and 7, in that order.
- R5: The serial link uses mode 0. SCLK idles low and is never high while chip select is high. MOSI carries the most significant bit first and changes only while SCLK is low. MISO is sampled on the rising SCLK edge.
- R6: The SCLK period is 2*FAST_HALF system clocks for a fast transfer and 2*SLOW_HALF for a slow one.
- R7: Chip select stays low for a whole transfer. It rises 2*HALF+1 system clocks after the last falling SCLK edge, and busy clears in the same cycle.
- R8: Every port write made while busy reads 1 is ignored. This covers the control register and the opcode, address and payload registers.
- R9: A control write with upper nibble 0x2 (slow) or 0x3 (fast) enters page mode, and status bit 6 reads 1. The first accepted memory write sends the opcode, then the memory address bytes [23:16], [15:8] and [7:0], then the data byte. Each later write sends its data byte alone, all within one chip-select assertion.
- R10: A page session accepts at most PAGE_BYTES data bytes. Any memory write beyond that limit is ignored. A control write of 0x00 in page mode releases chip select and returns status to 0x00.
- R11: Offsets 1 to 4 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 3 | Port register offset |
| io_wr | input | 1 | Port write strobe |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data for io_addr |
| mem_wr | input | 1 | Memory write strobe, used in page mode |
| mem_addr | input | 24 | Memory write address |
| mem_wdata | input | 8 | Memory write data |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two things can land in the same cycle. One is a host control or register write. The other is a transfer the engine is still running, including the chip-select tail at its end. The bench provokes this by writing a new control byte and a new opcode right after starting a long eight-byte transfer. It then checks three things: the wire carries only the original bytes, exactly one chip-select assertion occurs, and the opcode register still holds its old value. The same collision is provoked in page mode with memory writes past the byte cap. The bench judges it by the total byte count seen on the wire.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_PG_IDLE,
        ST_PG_SHIFT
    } eng_state_t;

    typedef enum logic [2:0] {
        SRC_OPC,
        SRC_ADR_HI,
        SRC_ADR_MID,
        SRC_ADR_LO,
        SRC_DATA,
        SRC_FILL
    } byte_src_t;

    typedef struct packed {
        logic [3:0] kind;
        logic [1:0] rcnt;
        logic [1:0] wcode;
    } ctrl_t;

    localparam logic [3:0] KIND_PG_SLOW  = 4'h2;
    localparam logic [3:0] KIND_PG_FAST  = 4'h3;
    localparam logic [3:0] KIND_CMD_SLOW = 4'h4;
    localparam logic [3:0] KIND_CMD_FAST = 4'h5;

    localparam int PG_LAST_IDX = 4;

    function automatic logic [2:0] wlen_of(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    function automatic byte_src_t cmd_src(input logic [1:0] code, input logic [2:0] idx);
        if (idx == 3'd0)            return SRC_OPC;
        if (idx >= wlen_of(code))   return SRC_FILL;
        if (code == 2'd1)           return SRC_DATA;
        if (idx == 3'd1)            return SRC_ADR_HI;
        if (idx == 3'd2)            return SRC_ADR_MID;
        if (idx == 3'd3)            return SRC_ADR_LO;
        return SRC_DATA;
    endfunction

    function automatic byte_src_t pg_src(input logic [2:0] idx);
        case (idx)
            3'd0:    return SRC_OPC;
            3'd1:    return SRC_ADR_HI;
            3'd2:    return SRC_ADR_MID;
            3'd3:    return SRC_ADR_LO;
            default: return SRC_DATA;
        endcase
    endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fast,
    output logic tick
);
    localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = fast ? CNT_W'(FAST_HALF - 1) : CNT_W'(SLOW_HALF - 1);
    assign tick  = en && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> (cnt == '0)); // R6

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       active,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic [7:0] sreg;
    logic [2:0] bitn;

    assign mosi = active ? sreg[7] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            bitn    <= '0;
            active  <= 1'b0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                sreg   <= tx_byte;
                bitn   <= '0;
                active <= 1'b1;
                sclk   <= 1'b0;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                        sreg <= {sreg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        start |-> !active); // R5
    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (active && sclk) |-> $stable(mosi)); // R5

endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_eng_pkg::*;
#(
    parameter int FAST_HALF  = 2,
    parameter int SLOW_HALF  = 4,
    parameter int PAGE_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  io_addr,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic        mem_wr,
    input  logic [23:0] mem_addr,
    input  logic [7:0]  mem_wdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int PG_CNT_W = $clog2(PAGE_BYTES + 1);

    eng_state_t        st;
    ctrl_t             ctrl_in;
    logic [1:0]        wcode_q;
    logic [1:0]        rcnt_q;
    logic              fast_q;
    logic [7:0]        opc_q, adr_hi_q, adr_mid_q, adr_lo_q, dat_q;
    logic [7:0]        rx_q [3];
    logic [23:0]       pg_addr_q;
    logic [7:0]        pg_data_q;
    logic [PG_CNT_W-1:0] pg_cnt;
    logic              pg_started;
    logic [2:0]        idx;
    logic              launch;
    logic              sh_start;
    logic              gap_half;
    logic              busy, pg_mode;
    logic              ctrl_wr;
    logic              tick, sh_active, sh_done;
    logic [7:0]        sh_rx;
    logic [7:0]        tx_byte;
    logic [2:0]        wlen;
    logic [3:0]        total;
    logic [2:0]        rd_slot;
    byte_src_t         src;

    assign ctrl_in = ctrl_t'(io_wdata);
    assign ctrl_wr = io_wr && (io_addr == 3'd0);
    assign busy    = (st == ST_CMD) || (st == ST_GAP) || (st == ST_PG_SHIFT);
    assign pg_mode = (st == ST_PG_IDLE) || (st == ST_PG_SHIFT);
    assign wlen    = wlen_of(wcode_q);
    assign total   = {1'b0, wlen} + {2'b00, rcnt_q};
    assign rd_slot = idx - wlen;

    // byte selection for the shifter
    always_comb begin
        src = pg_mode ? pg_src(idx) : cmd_src(wcode_q, idx);
        case (src)
            SRC_OPC:     tx_byte = opc_q;
            SRC_ADR_HI:  tx_byte = pg_mode ? pg_addr_q[23:16] : adr_hi_q;
            SRC_ADR_MID: tx_byte = pg_mode ? pg_addr_q[15:8]  : adr_mid_q;
            SRC_ADR_LO:  tx_byte = pg_mode ? pg_addr_q[7:0]   : adr_lo_q;
            SRC_DATA:    tx_byte = pg_mode ? pg_data_q : dat_q;
            default:     tx_byte = 8'h00;
        endcase
    end

    // port read mux
    always_comb begin
        case (io_addr)
            3'd0:    io_rdata = {busy, pg_mode, 6'b0};
            3'd1:    io_rdata = opc_q;
            3'd2:    io_rdata = adr_lo_q;
            3'd3:    io_rdata = adr_mid_q;
            3'd4:    io_rdata = adr_hi_q;
            3'd5:    io_rdata = rx_q[0];
            3'd6:    io_rdata = rx_q[1];
            default: io_rdata = rx_q[2];
        endcase
    end

    // data registers: writable only while not busy
    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q     <= '0;
            adr_hi_q  <= '0;
            adr_mid_q <= '0;
            adr_lo_q  <= '0;
            dat_q     <= '0;
        end else if (io_wr && !busy) begin
            case (io_addr)
                3'd1:    opc_q     <= io_wdata;
                3'd2:    adr_lo_q  <= io_wdata;
                3'd3:    adr_mid_q <= io_wdata;
                3'd4:    adr_hi_q  <= io_wdata;
                3'd7:    dat_q     <= io_wdata;
                default: ;
            endcase
        end
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            wcode_q    <= '0;
            rcnt_q     <= '0;
            fast_q     <= 1'b0;
            idx        <= '0;
            launch     <= 1'b0;
            sh_start   <= 1'b0;
            gap_half   <= 1'b0;
            spi_cs_n   <= 1'b1;
            pg_cnt     <= '0;
            pg_started <= 1'b0;
            pg_addr_q  <= '0;
            pg_data_q  <= '0;
            for (int i = 0; i < 3; i++) rx_q[i] <= '0;
        end else begin
            sh_start <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (ctrl_wr) begin
                        if (ctrl_in.kind == KIND_CMD_SLOW || ctrl_in.kind == KIND_CMD_FAST) begin
                            wcode_q  <= ctrl_in.wcode;
                            rcnt_q   <= ctrl_in.rcnt;
                            fast_q   <= ctrl_in.kind[0];
                            idx      <= '0;
                            launch   <= 1'b1;
                            spi_cs_n <= 1'b0;
                            st       <= ST_CMD;
                        end else if (ctrl_in.kind == KIND_PG_SLOW || ctrl_in.kind == KIND_PG_FAST) begin
                            fast_q     <= ctrl_in.kind[0];
                            pg_cnt     <= '0;
                            pg_started <= 1'b0;
                            st         <= ST_PG_IDLE;
                        end
                    end
                end
                ST_CMD: begin
                    if (launch) begin
                        sh_start <= 1'b1;
                        launch   <= 1'b0;
                    end else if (sh_done) begin
                        if (idx >= wlen) rx_q[rd_slot[1:0]] <= sh_rx;
                        if ({1'b0, idx} == total - 4'd1) begin
                            st       <= ST_GAP;
                            gap_half <= 1'b0;
                        end else begin
                            idx    <= idx + 1'b1;
                            launch <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            spi_cs_n <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                ST_PG_IDLE: begin
                    if (ctrl_wr && io_wdata == 8'h00) begin
                        st       <= pg_started ? ST_GAP : ST_IDLE;
                        gap_half <= 1'b0;
                    end else if (mem_wr && pg_cnt < PG_CNT_W'(PAGE_BYTES)) begin
                        pg_addr_q  <= mem_addr;
                        pg_data_q  <= mem_wdata;
                        spi_cs_n   <= 1'b0;
                        idx        <= pg_started ? 3'(PG_LAST_IDX) : 3'd0;
                        pg_started <= 1'b1;
                        launch     <= 1'b1;
                        st         <= ST_PG_SHIFT;
                    end
                end
                ST_PG_SHIFT: begin
                    if (launch) begin
                        sh_start <= 1'b1;
                        launch   <= 1'b0;
                    end else if (sh_done) begin
                        if (idx == 3'(PG_LAST_IDX)) begin
                            pg_cnt <= pg_cnt + 1'b1;
                            st     <= ST_PG_IDLE;
                        end else begin
                            idx    <= idx + 1'b1;
                            launch <= 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    spi_tick_gen #(
        .FAST_HALF(FAST_HALF),
        .SLOW_HALF(SLOW_HALF)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (sh_active || (st == ST_GAP)),
        .fast (fast_q),
        .tick (tick)
    );

    spi_byte_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .active  (sh_active),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R5
    AST_BUSY_WITH_CS: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && !pg_mode) |-> busy); // R7
    AST_CS_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> !busy); // R7
    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_wr) |=> ($stable(wcode_q) && $stable(rcnt_q) && $stable(fast_q))); // R8
    AST_PAGE_CAP: assert property (@(posedge clk) disable iff (rst)
        pg_cnt <= PG_CNT_W'(PAGE_BYTES)); // R10

endmodule

// File: tb/spi_port_engine_bench.sv
`timescale 1ns/1ps
module spi_port_engine_bench;
    localparam int FH = 2;
    localparam int SH = 4;
    localparam int PB = 256;
    localparam real TCLK = 4.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        mem_wr = 1'b0;
    logic [23:0] mem_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int errors = 0;
    int checks = 0;

    always #(TCLK/2) clk = ~clk;

    spi_port_engine #(.FAST_HALF(FH), .SLOW_HALF(SH), .PAGE_BYTES(PB)) u_spi_port_engine (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash-side model: response byte k of a session is 0xA0+k
    int        bitcnt = 0;
    int        cap_n = 0;
    int        cs_falls = 0;
    int        nrise = 0;
    logic [7:0] shreg = '0;
    logic [7:0] cap [0:299];
    realtime   t_r1, t_r2, t_fall, t_csr;

    function automatic logic resp_bit(input int b);
        logic [7:0] v;
        v = 8'hA0 + 8'(b / 8);
        return v[7 - (b % 8)];
    endfunction

    assign spi_miso = resp_bit(bitcnt);

    always @(negedge spi_cs_n) begin
        cs_falls++;
        cap_n  = 0;
        bitcnt = 0;
        nrise  = 0;
    end
    always @(posedge spi_sclk) begin
        shreg = {shreg[6:0], spi_mosi};
        bitcnt++;
        nrise++;
        if (nrise == 1) t_r1 = $realtime;
        if (nrise == 2) t_r2 = $realtime;
        if (bitcnt % 8 == 0 && cap_n < 300) begin
            cap[cap_n] = shreg;
            cap_n++;
        end
    end
    always @(negedge spi_sclk) t_fall = $realtime;
    always @(posedge spi_cs_n) t_csr = $realtime;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk);
            io_addr = 3'd0;
            #1;
        end while (io_rdata[7]);
    endtask

    task automatic mem_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
        wait_idle();
    endtask

    // {ctrl, opcode, off4, off3, off2, off7}
    localparam logic [47:0] VEC [8] = '{
        48'h40_05_00_00_00_00,
        48'h51_06_00_00_00_9C,
        48'h5E_03_12_34_56_00,
        48'h4F_0B_AB_CD_EF_77,
        48'h48_9F_00_00_00_00,
        48'h57_02_01_02_03_C3,
        48'h5D_35_00_00_00_E1,
        48'h46_4B_7F_80_81_00
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic [7:0] expb [0:7];
        int         nexp;
        int         falls0;

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        io_read(3'd0, d);
        chk(d == 8'h00, "R1 status after reset", d, 8'h00);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins after reset", {spi_cs_n, spi_sclk}, 2'b10);

        // table-driven command transfers
        for (int v = 0; v < 8; v++) begin
            logic [7:0] c, op, ah, am, al, dt;
            int wl, rc;
            {c, op, ah, am, al, dt} = VEC[v];
            io_write(3'd1, op);
            io_write(3'd4, ah);
            io_write(3'd3, am);
            io_write(3'd2, al);
            io_write(3'd7, dt);
            falls0 = cs_falls;
            io_write(3'd0, c);
            io_addr = 3'd0;
            #1;
            chk(io_rdata[7] == 1'b1, "R2 busy after start", io_rdata, 8'h80);
            wait_idle();
            case (c[1:0])
                2'd0: wl = 1;
                2'd1: wl = 2;
                2'd2: wl = 4;
                default: wl = 5;
            endcase
            rc = int'(c[3:2]);
            expb[0] = op;
            if (c[1:0] == 2'd1) expb[1] = dt;
            if (c[1]) begin expb[1] = ah; expb[2] = am; expb[3] = al; end
            if (c[1:0] == 2'd3) expb[4] = dt;
            for (int j = 0; j < rc; j++) expb[wl + j] = 8'h00;
            nexp = wl + rc;
            chk(cs_falls == falls0 + 1, "R7 one chip-select per transfer", cs_falls - falls0, 1);
            chk(cap_n == nexp, "R3 byte count on wire", cap_n, nexp);
            for (int j = 0; j < nexp; j++)
                chk(cap[j] == expb[j], (j < wl) ? "R3 wire byte" : "R4 fill byte", cap[j], expb[j]);
            for (int j = 0; j < rc; j++) begin
                io_read(3'(5 + j), d);
                chk(d == 8'(8'hA0 + wl + j), "R4 read-back byte", d, 8'(8'hA0 + wl + j));
            end
            if (c[4])
                chk(t_r2 - t_r1 == 2.0 * FH * TCLK, "R6 fast period", int'(t_r2 - t_r1), int'(2 * FH * TCLK));
            else
                chk(t_r2 - t_r1 == 2.0 * SH * TCLK, "R6 slow period", int'(t_r2 - t_r1), int'(2 * SH * TCLK));
            chk(t_csr - t_fall == (c[4] ? 2.0 * FH + 1.0 : 2.0 * SH + 1.0) * TCLK,
                "R7 chip-select tail", int'(t_csr - t_fall),
                int'((c[4] ? 2 * FH + 1 : 2 * SH + 1) * TCLK));
            chk(spi_sclk == 1'b0, "R5 sclk idles low", spi_sclk, 0);
        end

        // register read-back
        io_write(3'd1, 8'h5A); io_write(3'd2, 8'h11); io_write(3'd3, 8'h22); io_write(3'd4, 8'h33);
        io_read(3'd1, d); chk(d == 8'h5A, "R11 offset 1", d, 8'h5A);
        io_read(3'd2, d); chk(d == 8'h11, "R11 offset 2", d, 8'h11);
        io_read(3'd3, d); chk(d == 8'h22, "R11 offset 3", d, 8'h22);
        io_read(3'd4, d); chk(d == 8'h33, "R11 offset 4", d, 8'h33);

        // invalid control codes
        falls0 = cs_falls;
        io_write(3'd0, 8'h64);
        io_write(3'd0, 8'h14);
        repeat (20) @(negedge clk);
        io_read(3'd0, d);
        chk(d == 8'h00, "R2 invalid code leaves status", d, 8'h00);
        chk(cs_falls == falls0 && spi_cs_n, "R2 invalid code no transfer", cs_falls - falls0, 0);

        // writes while busy are ignored
        io_write(3'd1, 8'hC7);
        falls0 = cs_falls;
        io_write(3'd0, 8'h5F);
        io_write(3'd0, 8'h40);
        io_write(3'd1, 8'hEE);
        wait_idle();
        repeat (30) @(negedge clk);
        chk(cs_falls == falls0 + 1, "R8 no second transfer", cs_falls - falls0, 1);
        chk(cap_n == 8, "R8 original length kept", cap_n, 8);
        chk(cap[0] == 8'hC7, "R8 original opcode sent", cap[0], 8'hC7);
        io_read(3'd1, d);
        chk(d == 8'hC7, "R8 opcode write ignored", d, 8'hC7);

        // page mode, slow clock
        io_write(3'd1, 8'h02);
        falls0 = cs_falls;
        io_write(3'd0, 8'h20);
        io_read(3'd0, d);
        chk(d == 8'h40, "R9 page-mode status", d, 8'h40);
        for (int n = 0; n < PB + 2; n++)
            mem_write(24'h123456 + 24'(n), 8'(n) ^ 8'h5A);
        chk(spi_cs_n == 1'b0, "R9 chip select held", spi_cs_n, 0);
        io_write(3'd0, 8'h00);
        wait_idle();
        io_read(3'd0, d);
        chk(d == 8'h00, "R10 page-mode exit status", d, 8'h00);
        chk(spi_cs_n == 1'b1, "R10 chip select released", spi_cs_n, 1);
        chk(cs_falls == falls0 + 1, "R9 single chip-select session", cs_falls - falls0, 1);
        chk(cap_n == 4 + PB, "R10 byte cap", cap_n, 4 + PB);
        chk(cap[0] == 8'h02, "R9 page opcode", cap[0], 8'h02);
        chk({cap[1], cap[2], cap[3]} == 24'h123456, "R9 page address", {cap[1], cap[2], cap[3]}, 24'h123456);
        begin
            int bad;
            bad = 0;
            for (int n = 0; n < PB; n++)
                if (cap[4 + n] != (8'(n) ^ 8'h5A)) bad++;
            chk(bad == 0, "R9 page data bytes", bad, 0);
        end

        // page mode entered and left with no data: no chip select
        falls0 = cs_falls;
        io_write(3'd0, 8'h30);
        io_write(3'd0, 8'h00);
        repeat (10) @(negedge clk);
        io_read(3'd0, d);
        chk(d == 8'h00 && cs_falls == falls0, "R10 empty session", {d, 8'(cs_falls - falls0)}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule